// File: doc/BRIEF.md
# Per-Array Access Permission Checker

This block decides, byte by byte, whether a memory request may proceed. The memory is split into four arrays of 128 bytes. Two 8-bit control registers give each array a 4-bit rule. Two bits of that rule pick a functional lock level. The other two bits say whether a write needs the write password and whether a read needs the read password. The controller around the block supplies several inputs with each request byte: the 9-bit address, the direction, the stored byte, the byte to be written, a flag that the relevant password has been verified, and a flag that configuration mode is active.

The block returns three results. `allow` is combinational and says the byte may be transferred. `pwd_need` says a password applies to the request. `violation` is a registered one-cycle pulse that tells the controller to drop the transaction, answer with no-acknowledge and return to standby.

An array in program-only mode accepts a write only when no bit goes from 0 to 1. After any refusal, the rest of the transaction is refused without further pulses. This lasts until the request line drops.

Top module: `acc_perm_check`

## Requirements
- R1: The array is chosen by address bits [8:7]. Array 0 uses `ctrl_lo[3:0]`, array 1 uses `ctrl_lo[7:4]`, array 2 uses `ctrl_hi[3:0]` and array 3 uses `ctrl_hi[7:4]`. Within a nibble, bit 3 is the write-password flag, bit 2 is the read-password flag, bit 1 is Z and bit 0 is T.
- R2: With {Z,T}=00, both reads and writes are allowed, subject to passwords.
- R3: With {Z,T}=10, reads are allowed and writes are refused.
- R4: With {Z,T}=01, reads are allowed. A write is allowed only if `(~old_byte & new_byte) == 0`.
- R5: With {Z,T}=11, no read or write is allowed outside configuration mode.
- R6: `pwd_need` follows nibble bit 3 for a write (`req_write`=1) and nibble bit 2 for a read. It is 1 whenever `cfg_mode` is 1.
- R7: A request with `pwd_need`=1 and `pwd_ok`=0 is refused.
- R8: With `cfg_mode`=1 and `pwd_ok`=1, every request is allowed regardless of the nibble. With `cfg_mode`=1 and `pwd_ok`=0, every request is refused.
- R9: `allow` is 0 while `req_valid` is 0.
- R10: A refused request with `req_valid`=1 raises `violation` in the following cycle, for exactly one cycle.
- R11: After a refusal, later bytes of the same transaction are refused and raise no further `violation`. A cycle with `req_valid`=0 ends the transaction and lifts the refusal.
- R12: The synchronous reset `rst` holds `violation` at 0 and clears the refusal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request byte is presented; a low cycle ends the transaction |
| req_addr | input | 9 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| old_byte | input | 8 | Byte currently stored at the address |
| new_byte | input | 8 | Byte to be written |
| pwd_ok | input | 1 | The password for this request was verified |
| cfg_mode | input | 1 | Configuration mode is active |
| ctrl_lo | input | 8 | Control register for arrays 0 and 1 |
| ctrl_hi | input | 8 | Control register for arrays 2 and 3 |
| allow | output | 1 | Byte may be transferred (combinational) |
| pwd_need | output | 1 | A password applies to this request |
| violation | output | 1 | One-cycle pulse: abort, no-acknowledge, standby |

## Verification
The bench sweeps every rule nibble into each of the four array slots. The other three slots hold the complement nibble, so a wrong nibble selection changes the outcome. Each placement is tried with both directions, both password states and both mode flags. Three data pairs are used for every case: one that only clears bits, one that sets a single bit, and one that rewrites the same value. Together these separate the program-only rule from the read-only and free rules. A multi-byte transaction on a program-only array then places a rising-bit byte between legal bytes. This shows that refusal sticks for the rest of the transaction, that the pulse appears once, and that the next transaction starts clean.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;

  // lock level, encoded as {Z,T}
  typedef enum logic [1:0] {
    FN_FREE   = 2'b00,
    FN_PROG   = 2'b01,
    FN_RDONLY = 2'b10,
    FN_LOCKED = 2'b11
  } fn_mode_e;

  // one nibble of a control register: {wr_pw, rd_pw, Z, T}
  typedef struct packed {
    logic     wr_pw;
    logic     rd_pw;
    fn_mode_e fn;
  } arr_rule_t;

  localparam int RULE_W = $bits(arr_rule_t);

endpackage

// File: rtl/acc_nibble_sel.sv
`timescale 1ns/1ps
module acc_nibble_sel
  import acc_pkg::*;
#(
  parameter int NUM_ARR = 4,
  localparam int SEL_W  = $clog2(NUM_ARR)
) (
  input  logic [NUM_ARR*RULE_W-1:0] ctrl_flat,
  input  logic [SEL_W-1:0]          sel,
  output arr_rule_t                 rule
);

  arr_rule_t rules [NUM_ARR];

  for (genvar g = 0; g < NUM_ARR; g++) begin : g_slot
    assign rules[g] = arr_rule_t'(ctrl_flat[g*RULE_W +: RULE_W]);
  end

  assign rule = rules[sel];

endmodule

// File: rtl/acc_rule_eval.sv
`timescale 1ns/1ps
module acc_rule_eval
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  arr_rule_t          rule,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  old_byte,
  input  logic [DATA_W-1:0]  new_byte,
  input  logic               pwd_ok,
  input  logic               cfg_mode,
  output logic               grant,
  output logic               pwd_need
);

  logic rising_bit;
  logic func_ok;

  // any stored 0 that would become 1
  assign rising_bit = |(~old_byte & new_byte);

  always_comb begin
    unique case (rule.fn)
      FN_FREE:   func_ok = 1'b1;
      FN_RDONLY: func_ok = !req_write;
      FN_PROG:   func_ok = !req_write || !rising_bit;
      default:   func_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (cfg_mode) begin
      pwd_need = 1'b1;
      grant    = pwd_ok;
    end else begin
      pwd_need = req_write ? rule.wr_pw : rule.rd_pw;
      grant    = func_ok && (!pwd_need || pwd_ok);
    end
  end

endmodule

// File: rtl/acc_abort_ctl.sv
`timescale 1ns/1ps
module acc_abort_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic grant,
  output logic allow,
  output logic violation
);

  logic aborted_q;
  logic viol_q;
  logic deny_now;

  assign deny_now  = req_valid && !grant && !aborted_q;
  assign allow     = req_valid && grant && !aborted_q;
  assign violation = viol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aborted_q <= 1'b0;
      viol_q    <= 1'b0;
    end else begin
      viol_q <= deny_now;
      if (!req_valid) aborted_q <= 1'b0;
      else if (deny_now) aborted_q <= 1'b1;
    end
  end

endmodule

// File: rtl/acc_perm_check.sv
`timescale 1ns/1ps
module acc_perm_check
  import acc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] old_byte,
  input  logic [DATA_W-1:0] new_byte,
  input  logic              pwd_ok,
  input  logic              cfg_mode,
  input  logic [CTRL_W-1:0] ctrl_lo,
  input  logic [CTRL_W-1:0] ctrl_hi,
  output logic              allow,
  output logic              pwd_need,
  output logic              violation
);

  localparam int NUM_ARR = 2 * CTRL_W / RULE_W;
  localparam int SEL_W   = $clog2(NUM_ARR);

  arr_rule_t        rule;
  logic             grant;
  logic [SEL_W-1:0] arr_sel;
  logic             unused_low_addr;

  assign arr_sel         = req_addr[ADDR_W-1 -: SEL_W];
  assign unused_low_addr = ^req_addr[ADDR_W-SEL_W-1:0];

  acc_nibble_sel #(.NUM_ARR(NUM_ARR)) u_sel (
    .ctrl_flat (({ctrl_hi, ctrl_lo})),
    .sel       (arr_sel),
    .rule      (rule)
  );

  acc_rule_eval #(.DATA_W(DATA_W)) u_eval (
    .rule      (rule),
    .req_write (req_write),
    .old_byte  (old_byte),
    .new_byte  (new_byte),
    .pwd_ok    (pwd_ok),
    .cfg_mode  (cfg_mode),
    .grant     (grant),
    .pwd_need  (pwd_need)
  );

  acc_abort_ctl u_abort (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .grant     (grant),
    .allow     (allow),
    .violation (violation)
  );

endmodule

// File: rtl/acc_perm_check_chk.sv
`timescale 1ns/1ps
module acc_perm_check_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [8:0] req_addr,
  input logic       req_write,
  input logic [7:0] old_byte,
  input logic [7:0] new_byte,
  input logic       pwd_ok,
  input logic       cfg_mode,
  input logic [7:0] ctrl_lo,
  input logic [7:0] ctrl_hi,
  input logic       allow,
  input logic       pwd_need,
  input logic       violation
);

  logic [15:0] flat;
  logic [3:0]  nib;
  assign flat = {ctrl_hi, ctrl_lo};
  assign nib  = flat[{req_addr[8:7], 2'b00} +: 4];

  p_idle_no_allow_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !allow);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    violation |=> !violation);

  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (rst)
    violation |-> $past(req_valid && !allow));

  p_prog_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !cfg_mode && nib[1:0] == 2'b01 &&
     ((~old_byte & new_byte) != 8'h00)) |-> !allow);

  p_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_mode && nib[1:0] == 2'b11) |-> !allow);

  p_pwd_missing_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pwd_need && !pwd_ok) |-> !allow);

endmodule

bind acc_perm_check acc_perm_check_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_write (req_write),
  .old_byte  (old_byte),
  .new_byte  (new_byte),
  .pwd_ok    (pwd_ok),
  .cfg_mode  (cfg_mode),
  .ctrl_lo   (ctrl_lo),
  .ctrl_hi   (ctrl_hi),
  .allow     (allow),
  .pwd_need  (pwd_need),
  .violation (violation)
);

// File: tb/tb_acc_perm_check.sv
`timescale 1ns/1ps
module tb_acc_perm_check;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [8:0] req_addr;
  logic       req_write;
  logic [7:0] old_byte;
  logic [7:0] new_byte;
  logic       pwd_ok;
  logic       cfg_mode;
  logic [7:0] ctrl_lo;
  logic [7:0] ctrl_hi;
  logic       allow;
  logic       pwd_need;
  logic       violation;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  acc_perm_check dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // model from the requirements
  function automatic logic exp_ok(input logic [3:0] nb, input logic wr,
                                  input logic [7:0] od, input logic [7:0] nw,
                                  input logic pw, input logic cf);
    logic need, f;
    if (cf) return pw;                                   // R8
    need = wr ? nb[3] : nb[2];
    case (nb[1:0])
      2'b00: f = 1'b1;                                   // R2
      2'b10: f = (wr == 1'b0);                           // R3
      2'b01: f = (wr == 1'b0) || ((od & nw) == nw);      // R4
      default: f = 1'b0;                                 // R5
    endcase
    return f && (pw || !need);                           // R7
  endfunction

  task automatic idle();
    req_valid = 0; req_addr = '0; req_write = 0; old_byte = '0;
    new_byte = '0; pwd_ok = 0; cfg_mode = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] od_t [3];
    logic [7:0] nw_t [3];
    od_t[0] = 8'hF0; nw_t[0] = 8'h30;   // clears only
    od_t[1] = 8'h0F; nw_t[1] = 8'h1F;   // raises bit 4
    od_t[2] = 8'hA5; nw_t[2] = 8'hA5;   // unchanged
    rst = 1'b1; idle(); ctrl_lo = '0; ctrl_hi = '0;
    @(negedge clk);
    // R12: a refused request during reset produces no pulse
    req_valid = 1; req_write = 1; ctrl_lo = 8'h03;
    @(negedge clk);
    chk("R12 reset violation", violation, 1'b0);
    idle();
    @(negedge clk);
    chk("R12 reset violation idle", violation, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle allow", allow, 1'b0);

    // exhaustive sweep
    for (int nb = 0; nb < 16; nb++)
      for (int a = 0; a < 4; a++)
        for (int m = 0; m < 24; m++) begin
          logic [15:0] fl;
          logic wr, pw, cf, e, en;
          int dp;
          wr = m[0]; pw = m[1]; cf = m[2]; dp = m / 8;
          for (int s = 0; s < 4; s++)
            fl[s*4 +: 4] = (s == a) ? nb[3:0] : ~nb[3:0];
          ctrl_lo = fl[7:0]; ctrl_hi = fl[15:8];
          req_valid = 1; req_write = wr; pwd_ok = pw; cfg_mode = cf;
          req_addr = {a[1:0], 7'(nb * 5 + m)};
          old_byte = od_t[dp]; new_byte = nw_t[dp];
          e  = exp_ok(nb[3:0], wr, od_t[dp], nw_t[dp], pw, cf);
          en = cf ? 1'b1 : (wr ? nb[3] : nb[2]);
          #1;
          chk("R1/R2/R3/R4/R5/R7/R8 allow", allow, e);
          chk("R6 pwd_need", pwd_need, en);
          @(negedge clk);
          chk("R10 violation raised", violation, !e);
          req_valid = 0;
          #1;
          chk("R9 allow when idle", allow, 1'b0);
          @(negedge clk);
          chk("R10 violation one cycle", violation, 1'b0);
        end

    // R11: sticky refusal inside a transaction on program-only array 2
    ctrl_lo = 8'h00; ctrl_hi = 8'h01;
    cfg_mode = 0; pwd_ok = 0; req_write = 1; req_valid = 1;
    req_addr = 9'h100; old_byte = 8'hFF; new_byte = 8'h0F;
    #1; chk("R11 first byte allowed", allow, 1'b1);
    @(negedge clk);
    req_addr = 9'h101; old_byte = 8'h00; new_byte = 8'h01;
    #1; chk("R11 rising byte refused", allow, 1'b0);
    chk("R11 no pulse for legal byte", violation, 1'b0);
    @(negedge clk);
    req_addr = 9'h102; old_byte = 8'hFF; new_byte = 8'h00;
    #1; chk("R11 legal byte after refusal", allow, 1'b0);
    chk("R10 pulse after refusal", violation, 1'b1);
    @(negedge clk);
    req_addr = 9'h103; old_byte = 8'h00; new_byte = 8'h01;
    #1; chk("R11 no second pulse", violation, 1'b0);
    @(negedge clk);
    chk("R11 still quiet", violation, 1'b0);
    req_valid = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 9'h104; old_byte = 8'hF0; new_byte = 8'h80;
    #1; chk("R11 new transaction allowed", allow, 1'b1);
    @(negedge clk);
    chk("R11 no pulse on new transaction", violation, 1'b0);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule